// File: doc/BRIEF.md
# Grouped Interrupt Priority Resolver

This block chooses, from a set of pending exception requests, the one that should be serviced next. Three system sources (reset, non-maskable interrupt and hard fault) carry built-in priorities that outrank every programmable level. Every other source has a 4-bit programmable priority, where a smaller number means a more urgent request.

A 3-bit split setting divides each programmable priority into an upper group field and a lower subpriority field. The winner is found by comparing the group field first, then the subpriority, then the exception number, where the lowest number wins. The selection logic is combinational. Its result is captured in an output register, so a request pattern applied before a clock edge shows up on the outputs just after that edge. Deciding whether the winner preempts the running handler is left to the consumer. That consumer uses the reported group field for the decision.

Top module: `irq_res_top`

## Requirements
- R1: The three system sources always outrank every programmable source and are ranked reset > NMI > hard fault. `fixed_req` bit 0 is reset, bit 1 is NMI and bit 2 is hard fault. They are reported as exception numbers 1, 2 and 3, with group values -3, -2 and -1 (6-bit two's complement) and subpriority 0.
- R2: Programmable source k (bit k of `irq_req`, priority `irq_prio[4k+3:4k]`) is reported as exception number k+4.
- R3: With `sub_bits` = 0 the whole 4-bit priority is the group field, and a numerically smaller priority wins.
- R4: With `sub_bits` = s, the reported group is the priority shifted right by s, and the reported subpriority is the low s bits of the priority. The group field is compared first.
- R5: `sub_bits` values 5, 6 and 7 behave exactly like 4.
- R6: Among pending programmable sources with equal group fields, the smaller subpriority wins.
- R7: When group and subpriority are both equal, the lowest exception number wins.
- R8: When nothing is pending, `win_valid` is 0 and `win_num`, `win_group` and `win_sub` are all 0.
- R9: The outputs are registered. They reflect the inputs sampled at the previous rising edge of `clk`, stay unchanged between edges, and read as all zero while `rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fixed_req | input | 3 | Pending system sources: bit0 reset, bit1 NMI, bit2 hard fault |
| irq_req | input | NUM_IRQ | Pending programmable sources |
| irq_prio | input | 4*NUM_IRQ | Packed 4-bit priority per programmable source |
| sub_bits | input | 3 | Number of subpriority bits (saturates at 4) |
| win_valid | output | 1 | A winner exists |
| win_num | output | 8 | Winning exception number |
| win_group | output | 6 | Winner group value, signed |
| win_sub | output | 4 | Winner subpriority |

## Verification
Every result is due exactly one rising edge after the inputs that produce it. Reset clearing takes effect on the same edge that samples `rst`. The bench changes inputs only on falling edges and computes the expected winner from the inputs it has just applied. It then waits for the next rising edge and compares all four outputs one time unit later. One directed case also samples the outputs after new inputs are applied but before the edge, to confirm that the previous result is still held.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;

    localparam int PRIO_W  = 4;
    localparam int GRP_W   = 6;
    localparam int NUM_W   = 8;
    localparam int N_FIXED = 3;
    localparam logic [2:0] MAX_SUB = 3'd4;

    typedef logic signed [GRP_W-1:0] grp_t;

    typedef struct packed {
        logic              valid;
        grp_t              grp;
        logic [PRIO_W-1:0] sub;
        logic [NUM_W-1:0]  num;
    } cand_t;

    // clamp the split setting to the priority width
    function automatic logic [2:0] sat_sub(input logic [2:0] s);
        return (s > MAX_SUB) ? MAX_SUB : s;
    endfunction

    // split a programmable priority into group and subpriority
    function automatic cand_t split_prio(input logic              v,
                                         input logic [PRIO_W-1:0] p,
                                         input logic [2:0]        s,
                                         input logic [NUM_W-1:0]  n);
        cand_t c;
        c.valid = v;
        c.num   = n;
        case (s)
            3'd0:    begin c.grp = {2'b00, p};        c.sub = 4'd0;            end
            3'd1:    begin c.grp = {3'b000, p[3:1]};  c.sub = {3'b000, p[0]};  end
            3'd2:    begin c.grp = {4'b0000, p[3:2]}; c.sub = {2'b00, p[1:0]}; end
            3'd3:    begin c.grp = {5'b00000, p[3]};  c.sub = {1'b0, p[2:0]};  end
            default: begin c.grp = '0;                c.sub = p;               end
        endcase
        return c;
    endfunction

    // does candidate b strictly beat candidate a (a holds the lower number)
    function automatic logic beats(input cand_t b, input cand_t a);
        if (!b.valid) return 1'b0;
        if (!a.valid) return 1'b1;
        if ($signed(b.grp) < $signed(a.grp)) return 1'b1;
        if ((b.grp == a.grp) && (b.sub < a.sub)) return 1'b1;
        return 1'b0;
    endfunction

    function automatic cand_t pick(input cand_t lo, input cand_t hi);
        return beats(hi, lo) ? hi : lo;
    endfunction

endpackage

// File: rtl/irq_res_leaf.sv
module irq_res_leaf
    import irq_res_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    localparam int TOTAL  = NUM_IRQ + N_FIXED
) (
    input  logic [N_FIXED-1:0]        fixed_req,
    input  logic [NUM_IRQ-1:0]        irq_req,
    input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
    input  logic [2:0]                sub_bits,
    output cand_t [TOTAL-1:0]         leaves
);

    logic [2:0] eff_sub;
    assign eff_sub = sat_sub(sub_bits);

    // system sources: fixed negative group, number = index + 1
    for (genvar j = 0; j < N_FIXED; j++) begin : g_fixed
        assign leaves[j] = '{valid: fixed_req[j],
                             grp:   grp_t'(j - N_FIXED),
                             sub:   '0,
                             num:   NUM_W'(j + 1)};
    end

    // programmable sources: number = k + 4
    for (genvar k = 0; k < NUM_IRQ; k++) begin : g_prog
        assign leaves[N_FIXED + k] = split_prio(irq_req[k],
                                                irq_prio[k*PRIO_W +: PRIO_W],
                                                eff_sub,
                                                NUM_W'(k + N_FIXED + 1));
    end

endmodule

// File: rtl/irq_res_tree.sv
module irq_res_tree
    import irq_res_pkg::*;
#(
    parameter int N = 35
) (
    input  cand_t [N-1:0] leaves,
    output cand_t         best
);

    localparam int DEPTH  = (N > 1) ? $clog2(N) : 1;
    localparam int LEAVES = 1 << DEPTH;

    // heap layout: node i has children 2i and 2i+1, leaves from LEAVES
    cand_t node [2*LEAVES];

    assign node[0] = '0;

    for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
        if (j < N) begin : g_used
            assign node[LEAVES + j] = leaves[j];
        end else begin : g_pad
            assign node[LEAVES + j] = '0;
        end
    end

    // left child always carries lower exception numbers, so ties keep it
    for (genvar i = 1; i < LEAVES; i++) begin : g_node
        assign node[i] = pick(node[2*i], node[2*i + 1]);
    end

    assign best = node[1];

endmodule

// File: rtl/irq_res_top.sv
module irq_res_top
    import irq_res_pkg::*;
#(
    parameter int NUM_IRQ = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [2:0]                fixed_req,
    input  logic [NUM_IRQ-1:0]        irq_req,
    input  logic [NUM_IRQ*4-1:0]      irq_prio,
    input  logic [2:0]                sub_bits,
    output logic                      win_valid,
    output logic [7:0]                win_num,
    output logic [5:0]                win_group,
    output logic [3:0]                win_sub
);

    localparam int TOTAL = NUM_IRQ + N_FIXED;

    cand_t [TOTAL-1:0] leaves;
    cand_t             best;
    cand_t             win_q;

    irq_res_leaf #(.NUM_IRQ(NUM_IRQ)) i_leaf (
        .fixed_req (fixed_req),
        .irq_req   (irq_req),
        .irq_prio  (irq_prio),
        .sub_bits  (sub_bits),
        .leaves    (leaves)
    );

    irq_res_tree #(.N(TOTAL)) i_tree (
        .leaves (leaves),
        .best   (best)
    );

    always_ff @(posedge clk) begin
        if (rst || !best.valid) begin
            win_q <= '0;
        end else begin
            win_q <= best;
        end
    end

    assign win_valid = win_q.valid;
    assign win_num   = win_q.num;
    assign win_group = win_q.grp;
    assign win_sub   = win_q.sub;

endmodule

// File: rtl/irq_res_chk.sv
module irq_res_chk #(
    parameter int NUM_IRQ = 32
) (
    input logic               clk,
    input logic               rst,
    input logic [2:0]         fixed_req,
    input logic [NUM_IRQ-1:0] irq_req,
    input logic               win_valid,
    input logic [7:0]         win_num,
    input logic [5:0]         win_group,
    input logic [3:0]         win_sub
);

    logic [NUM_IRQ-1:0] req_q;
    logic [NUM_IRQ-1:0] req_sh;

    always_ff @(posedge clk) req_q <= irq_req;
    assign req_sh = req_q >> (win_num - 8'd4);

    a_r1_reset_first: assert property (@(posedge clk) disable iff (rst)
        fixed_req[0] |=> (win_valid && win_num == 8'd1));

    a_r1_fixed_fields: assert property (@(posedge clk) disable iff (rst)
        (win_valid && win_num >= 8'd1 && win_num <= 8'd3) |->
            ($signed(win_group) == $signed(6'(int'(win_num) - 4)) && win_sub == 4'd0));

    a_r1_fixed_outrank: assert property (@(posedge clk) disable iff (rst)
        (|fixed_req) |=> (win_valid && win_num <= 8'd3));

    a_r2_winner_pending: assert property (@(posedge clk) disable iff (rst)
        (win_valid && win_num >= 8'd4) |-> (req_sh[0] && !win_group[5]));

    a_r8_idle: assert property (@(posedge clk) disable iff (rst)
        (fixed_req == 3'd0 && irq_req == '0) |=>
            (!win_valid && win_num == 8'd0 && win_group == 6'd0 && win_sub == 4'd0));

    a_r8_busy: assert property (@(posedge clk) disable iff (rst)
        (fixed_req != 3'd0 || irq_req != '0) |=> win_valid);

    a_r9_reset_clear: assert property (@(posedge clk)
        rst |=> (!win_valid && win_num == 8'd0));

endmodule

bind irq_res_top irq_res_chk #(.NUM_IRQ(NUM_IRQ)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .fixed_req (fixed_req),
    .irq_req   (irq_req),
    .win_valid (win_valid),
    .win_num   (win_num),
    .win_group (win_group),
    .win_sub   (win_sub)
);

// File: tb/test_irq_res_top.sv
module test_irq_res_top;

    localparam int NUM_IRQ = 32;
    localparam int CLK_PERIOD = 10;

    logic                 clk = 1'b0;
    logic                 rst;
    logic [2:0]           fixed_req;
    logic [NUM_IRQ-1:0]   irq_req;
    logic [NUM_IRQ*4-1:0] irq_prio;
    logic [2:0]           sub_bits;
    logic                 win_valid;
    logic [7:0]           win_num;
    logic [5:0]           win_group;
    logic [3:0]           win_sub;

    int n_tests = 0;
    int n_fail  = 0;

    int e_valid, e_num, e_grp, e_sub;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_res_top #(.NUM_IRQ(NUM_IRQ)) i_irq_res_top (
        .clk(clk), .rst(rst), .fixed_req(fixed_req), .irq_req(irq_req),
        .irq_prio(irq_prio), .sub_bits(sub_bits), .win_valid(win_valid),
        .win_num(win_num), .win_group(win_group), .win_sub(win_sub)
    );

    // reference model built from the requirements
    task automatic model();
        int s, best_g, best_s, best_n, g, sb;
        bit found;
        s = (sub_bits > 3'd4) ? 4 : int'(sub_bits);
        found = 0; best_g = 0; best_s = 0; best_n = 0;
        for (int j = 0; j < 3; j++) begin
            if (fixed_req[j] && !found) begin
                found = 1; best_g = j - 3; best_s = 0; best_n = j + 1;
            end
        end
        for (int k = 0; k < NUM_IRQ; k++) begin
            if (irq_req[k]) begin
                g  = int'(irq_prio[k*4 +: 4]) >> s;
                sb = int'(irq_prio[k*4 +: 4]) & ((1 << s) - 1);
                if (!found || g < best_g || (g == best_g && sb < best_s)) begin
                    found = 1; best_g = g; best_s = sb; best_n = k + 4;
                end
            end
        end
        e_valid = found; e_num = best_n; e_grp = best_g; e_sub = best_s;
    endtask

    task automatic compare(input string tag);
        n_tests++;
        if (int'(win_valid) != e_valid || int'(win_num) != e_num ||
            int'($signed(win_group)) != e_grp || int'(win_sub) != e_sub) begin
            n_fail++;
            $display("FAIL %s: got v=%0d n=%0d g=%0d s=%0d expected v=%0d n=%0d g=%0d s=%0d",
                     tag, win_valid, win_num, $signed(win_group), win_sub,
                     e_valid, e_num, e_grp, e_sub);
        end
    endtask

    // inputs already applied after a falling edge; result due after next rise
    task automatic step(input string tag);
        model();
        @(posedge clk); #1;
        compare(tag);
        @(negedge clk);
    endtask

    task automatic clear_in();
        fixed_req = '0; irq_req = '0; irq_prio = '0; sub_bits = '0;
    endtask

    task automatic set_prio(input int k, input int p);
        irq_prio[k*4 +: 4] = 4'(p);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        clear_in();
        fixed_req = 3'b111; irq_req = '1;
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        // R9: outputs zero while reset is held despite pending requests
        e_valid = 0; e_num = 0; e_grp = 0; e_sub = 0;
        compare("R9 reset");
        rst = 1'b0;
        clear_in();

        // R8: nothing pending
        step("R8 idle");

        // R1: all pending, reset wins
        fixed_req = 3'b111; irq_req = '1; step("R1 reset wins");
        fixed_req = 3'b110; step("R1 nmi wins");
        fixed_req = 3'b100; step("R1 hard fault beats prio 0");

        // R3: smaller value wins with no split
        clear_in();
        irq_req[5] = 1; set_prio(5, 3);
        irq_req[9] = 1; set_prio(9, 1);
        step("R3 lower value wins");

        // R4/R6: split of 2, equal group 1, subpriority decides
        clear_in(); sub_bits = 3'd2;
        irq_req[2] = 1; set_prio(2, 6);
        irq_req[7] = 1; set_prio(7, 5);
        step("R4 R6 subpriority");
        // R4: group beats subpriority
        irq_req[12] = 1; set_prio(12, 3);
        step("R4 group first");

        // R5: setting 7 acts as 4
        clear_in(); sub_bits = 3'd7;
        irq_req[0] = 1; set_prio(0, 5);
        irq_req[1] = 1; set_prio(1, 3);
        step("R5 saturate");
        sub_bits = 3'd5; step("R5 saturate 5");

        // R7: full tie, lowest number
        clear_in(); sub_bits = 3'd1;
        irq_req[20] = 1; set_prio(20, 7);
        irq_req[3]  = 1; set_prio(3, 7);
        step("R7 tie lowest");
        clear_in();
        irq_req[31] = 1; irq_req[30] = 1; set_prio(31, 15); set_prio(30, 15);
        step("R7 tie top");

        // R2: single highest source
        clear_in(); irq_req[31] = 1; set_prio(31, 9);
        step("R2 numbering");

        // R9: output held until the edge
        clear_in(); fixed_req = 3'b010;
        #1;
        e_valid = 1; e_num = 35; e_grp = 9; e_sub = 0;
        compare("R9 hold before edge");
        step("R9 update after edge");

        // random mix: R3 R4 R6 R7
        for (int it = 0; it < 400; it++) begin
            fixed_req = ($urandom_range(0, 7) == 0) ? 3'($urandom) : 3'b000;
            irq_req   = $urandom & $urandom;
            for (int k = 0; k < NUM_IRQ; k++) set_prio(k, $urandom_range(0, 3) == 0 ? 2 : $urandom_range(0, 15));
            sub_bits  = 3'($urandom);
            step("R4 R6 R7 random");
        end

        // R9: reset mid-run clears
        fixed_req = 3'b001; rst = 1'b1;
        @(posedge clk); #1;
        e_valid = 0; e_num = 0; e_grp = 0; e_sub = 0;
        compare("R9 reset clears");
        @(negedge clk); rst = 1'b0;

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule